// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches over running software by means of a 7-bit down-counter. The counter advances once per tick. A tick is the peripheral clock divided by a fixed factor and then by a selectable prescaler. Software starts the watchdog by writing the control word with its top bit set. After that, software must service the watchdog inside a window: late enough that the counter has fallen to or below a programmed window value, and early enough that the counter has not yet passed 0x40. A service write that comes too soon is a fault, just as letting the counter run out is a fault. Either fault raises a one-cycle system reset request.

An optional early warning gives software one tick of notice. When enabled, an interrupt flag rises as the counter lands on 0x40, one tick before the reset request. A sticky status flag records that the watchdog caused a reset. This flag lives in the power-on domain, so it survives the system reset that the request triggers. Software can read it afterwards and remove it explicitly.

Writes use a single-cycle strobe with a 2-bit selector: 0 for the control word, 1 for the configuration word, 2 for the status word, and 3 for nothing. Two reset inputs are provided. `por_n` clears everything. `sys_rst_n` clears everything except the sticky status flag.

Top module: `wwdt_top`

## Requirements
- R1: After `por_n` is released, the watchdog is idle and `rst_req`, `irq` and `wdg_rst_flag` are all 0.
- R2: One counter tick lasts FIXED_DIV × 2^psc clock cycles, where psc is config bits [8:7] (0..3 select divide by 1, 2, 4 or 8).
- R3: A control write (selector 0) with bit 7 set activates an idle watchdog and loads the counter from bits [6:0]. A control write with bit 7 clear while idle has no effect, so no reset request ever follows it.
- R4: An unserviced watchdog loaded with L raises `rst_req` exactly (L−63) ticks after the activating write edge, when the counter steps from 0x40 to 0x3F. The count starts from the write edge, where the pulse is registered.
- R5: A control write with bit 7 set while active and while the counter is above the window value (config bits [6:0]) raises `rst_req` at that same write edge and does not reload the counter.
- R6: A control write with bit 7 set while active and while the counter is at or below the window value reloads the counter from bits [6:0], restarts the tick phase and raises no reset. The next expiry therefore follows (L−63) full ticks after that write.
- R7: Once active, the watchdog cannot be stopped by software. A control write with bit 7 clear changes neither the counter nor the expiry time.
- R8: With early-warning enable (config bit 9) set, `irq` rises at the tick where the counter reaches 0x40, one tick before `rst_req`. It stays high until a status write (selector 2) with bit 0 clear. With the enable clear, `irq` stays 0.
- R9: `wdg_rst_flag` is set with every `rst_req` pulse and survives `sys_rst_n`. Only a status write with bit 1 set, or `por_n`, clears it.
- R10: `sys_rst_n` deactivates the watchdog and clears the configuration and `irq`. No reset request follows until the watchdog is activated again.
- R11: `rst_req` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears all state |
| sys_rst_n | input | 1 | System reset, active low, synchronous; clears all but the sticky flag |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_sel | input | 2 | Word select: 0 control, 1 configuration, 2 status |
| wr_data | input | 10 | Write data |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Early-warning interrupt flag |
| wdg_rst_flag | output | 1 | Sticky watchdog-caused-reset flag |

## Verification
The counter and the tick phase are hidden, so a wrong internal value shows at the ports only as a `rst_req` or `irq` edge that comes early or late. An off-by-one in the counter moves the expiry by a whole tick. A wrong phase restart moves it by a fraction of a tick. A wrong window compare turns a good service into an immediate pulse at the write edge, or hides a fault.

The bench therefore measures expiry and warning edges against the write edge to the exact cycle. It also compares all three outputs against a behavioural model on every cycle, so any divergence shows up within one tick of its cause.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam int CNT_W  = 7;
  localparam int DATA_W = 10;

  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t WARN_VAL = 7'h40;
  localparam cnt_t LAST_OK  = 7'h41;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;

  // Clocks per tick for a given prescaler code.
  function automatic int unsigned tick_period(int unsigned fixed_div, logic [1:0] psc);
    return fixed_div << psc;
  endfunction

  // A service while the counter is still above the window is a fault.
  function automatic logic service_early(cnt_t cnt, cnt_t win);
    return cnt > win;
  endfunction
endpackage

// File: rtl/wwdt_tick.sv
module wwdt_tick import wwdt_pkg::*; #(
  parameter int FIXED_DIV = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] psc,
  output logic       tick
);
  localparam int PW = $clog2(FIXED_DIV * 8 + 1);

  logic [PW-1:0] phase;
  logic [PW-1:0] period;

  assign period = PW'(tick_period(FIXED_DIV, psc));
  assign tick   = run && (phase >= period - PW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                phase <= '0;
    else if (restart || !run)  phase <= '0;
    else if (tick)             phase <= '0;
    else                       phase <= phase + PW'(1);
  end
endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter import wwdt_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic activate,
  input  logic reload,
  input  cnt_t load_val,
  output cnt_t cnt,
  output logic active
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      if (activate) active <= 1'b1;
      if (activate || reload) cnt <= load_val;
      else if (tick && active) cnt <= cnt - cnt_t'(1);
    end
  end
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top import wwdt_pkg::*; #(
  parameter int FIXED_DIV = 4096
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rst_req,
  output logic              irq,
  output logic              wdg_rst_flag
);
  logic       blk_rst_n;
  cnt_t       cnt;
  cnt_t       win;
  logic [1:0] psc;
  logic       ewi;
  logic       active;
  logic       tick;

  // Named internal events.
  logic wr_ctrl, wr_cfg, wr_stat;
  logic service_req, activate, early_fault, reload;
  logic expire_ev, warn_ev, fault_ev, pulse_ev;
  logic irq_clr, flag_clr;

  assign blk_rst_n   = por_n && sys_rst_n;
  assign wr_ctrl     = wr_en && (wr_sel == SEL_CTRL);
  assign wr_cfg      = wr_en && (wr_sel == SEL_CFG);
  assign wr_stat     = wr_en && (wr_sel == SEL_STAT);
  assign service_req = wr_ctrl && wr_data[7];
  assign activate    = service_req && !active;
  assign early_fault = service_req && active && service_early(cnt, win);
  assign reload      = service_req && active && !service_early(cnt, win);
  assign expire_ev   = tick && (cnt == WARN_VAL) && !reload;
  assign warn_ev     = tick && (cnt == LAST_OK) && ewi && !reload;
  assign fault_ev    = early_fault || expire_ev;
  assign pulse_ev    = fault_ev && !rst_req;
  assign irq_clr     = wr_stat && !wr_data[0];
  assign flag_clr    = wr_stat && wr_data[1];

  wwdt_tick #(.FIXED_DIV(FIXED_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (blk_rst_n),
    .run     (active),
    .restart (reload),
    .psc     (psc),
    .tick    (tick)
  );

  wwdt_counter u_counter (
    .clk      (clk),
    .rst_n    (blk_rst_n),
    .tick     (tick),
    .activate (activate),
    .reload   (reload),
    .load_val (wr_data[6:0]),
    .cnt      (cnt),
    .active   (active)
  );

  always_ff @(posedge clk) begin
    if (!blk_rst_n) begin
      win <= '0;
      psc <= '0;
      ewi <= 1'b0;
      irq <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (wr_cfg) begin
        win <= wr_data[6:0];
        psc <= wr_data[8:7];
        ewi <= wr_data[9];
      end
      irq     <= warn_ev || (irq && !irq_clr);
      rst_req <= pulse_ev;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n)         wdg_rst_flag <= 1'b0;
    else if (!sys_rst_n) wdg_rst_flag <= wdg_rst_flag;
    else                wdg_rst_flag <= pulse_ev || (wdg_rst_flag && !flag_clr);
  end
endmodule

// File: rtl/wwdt_top_chk.sv
module wwdt_top_chk (
  input logic       clk,
  input logic       por_n,
  input logic       sys_rst_n,
  input logic       service_wr,
  input logic       flag_rmv_wr,
  input logic [6:0] load_val,
  input logic       rst_req,
  input logic       irq,
  input logic       wdg_rst_flag,
  input logic       active,
  input logic       tick,
  input logic [6:0] cnt,
  input logic [6:0] win
);
  // R11: reset request lasts one cycle
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
    rst_req |=> !rst_req);

  // R4: stepping off 0x40 without a good service raises the request
  a_r4_expire: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
    (tick && active && cnt == 7'h40 && !(service_wr && cnt <= win) && !rst_req) |=> rst_req);

  // R5: early service is a fault
  a_r5_early_fault: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
    (service_wr && active && cnt > win && !rst_req) |=> rst_req);

  // R6: service inside the window reloads the counter
  a_r6_reload: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
    (service_wr && active && cnt <= win) |=> (cnt == $past(load_val)));

  // R7: software cannot stop an active watchdog
  a_r7_stays_active: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
    active |=> active);

  // R8: warning rises exactly as the counter lands on 0x40
  a_r8_warn_point: assert property (@(posedge clk) disable iff (!(por_n && sys_rst_n))
    $rose(irq) |-> (cnt == 7'h40));

  // R9: the sticky flag holds until removed
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (wdg_rst_flag && !flag_rmv_wr) |=> wdg_rst_flag);

  // R9: every request is recorded
  a_r9_flag_set: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> wdg_rst_flag);
endmodule

bind wwdt_top wwdt_top_chk u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .sys_rst_n    (sys_rst_n),
  .service_wr   (wr_en && wr_sel == 2'd0 && wr_data[7]),
  .flag_rmv_wr  (wr_en && wr_sel == 2'd2 && wr_data[1]),
  .load_val     (wr_data[6:0]),
  .rst_req      (rst_req),
  .irq          (irq),
  .wdg_rst_flag (wdg_rst_flag),
  .active       (active),
  .tick         (tick),
  .cnt          (cnt),
  .win          (win)
);

// File: tb/wwdt_top_bench.sv
module wwdt_top_bench;
  localparam int FD = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       por_n = 1'b0, sys_rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [9:0] wr_data = 10'd0;
  wire        rst_req, irq, wdg_rst_flag;

  wwdt_top #(.FIXED_DIV(FD)) u_wwdt_top (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rst_req(rst_req), .irq(irq),
    .wdg_rst_flag(wdg_rst_flag)
  );

  int checks = 0, fails = 0, cyc = 0, t_wr = 0, npulse = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference model
  bit m_active, m_ewi, m_rst, m_irq, m_flag;
  int m_cnt, m_pcnt, m_win, m_psc;

  always @(posedge clk) begin
    int per, nc, np, ld;
    bit tk, sv, ev, wv, na, pulse, st;
    cyc++;
    if (!por_n) begin
      m_active = 0; m_ewi = 0; m_rst = 0; m_irq = 0; m_flag = 0;
      m_cnt = 0; m_pcnt = 0; m_win = 0; m_psc = 0;
    end else if (!sys_rst_n) begin
      m_active = 0; m_ewi = 0; m_rst = 0; m_irq = 0;
      m_cnt = 0; m_pcnt = 0; m_win = 0; m_psc = 0;
    end else begin
      per = FD * (1 << m_psc);
      tk  = m_active && (m_pcnt >= per - 1);
      sv  = wr_en && wr_sel == 2'd0 && wr_data[7];
      st  = wr_en && wr_sel == 2'd2;
      ld  = int'(wr_data[6:0]);
      ev = 0; wv = 0; na = m_active; nc = m_cnt;
      np = !m_active ? 0 : (tk ? 0 : m_pcnt + 1);
      if (tk) begin
        nc = (m_cnt + 127) % 128;
        if (m_cnt == 64) ev = 1;
        if (m_cnt == 65 && m_ewi) wv = 1;
      end
      if (sv) begin
        if (!m_active) begin na = 1; nc = ld; np = 0; end
        else if (m_cnt > m_win) ev = 1;
        else begin nc = ld; np = 0; ev = 0; wv = 0; end
      end
      pulse  = ev && !m_rst;
      m_flag = pulse || (m_flag && !(st && wr_data[1]));
      m_irq  = wv || (m_irq && !(st && !wr_data[0]));
      if (wr_en && wr_sel == 2'd1) begin
        m_win = int'(wr_data[6:0]); m_psc = int'(wr_data[8:7]); m_ewi = wr_data[9];
      end
      m_rst = pulse; m_cnt = nc; m_pcnt = np; m_active = na;
    end
  end

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cyc > 0) begin
      chk(rst_req === m_rst, tag, int'(rst_req), int'(m_rst));
      chk(irq === m_irq, tag, int'(irq), int'(m_irq));
      chk(wdg_rst_flag === m_flag, tag, int'(wdg_rst_flag), int'(m_flag));
      if (rst_req === 1'b1) npulse++;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [9:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    t_wr = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sreset();
    @(posedge clk); #1 sys_rst_n = 1'b0;
    @(posedge clk); #1 sys_rst_n = 1'b1;
  endtask

  task automatic wait_rst(input int maxc, output int at);
    at = -1;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (rst_req === 1'b1) begin at = cyc; break; end
    end
  endtask

  task automatic clear_flag();
    wr(2'd2, 10'h003);
    @(negedge clk);
    chk(wdg_rst_flag === 1'b0, "R9", int'(wdg_rst_flag), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int at, t0, ir, p0;
    idle(3);
    por_n = 1'b1; sys_rst_n = 1'b1;
    @(negedge clk);
    chk(rst_req === 1'b0, "R1", int'(rst_req), 0);
    chk(irq === 1'b0, "R1", int'(irq), 0);
    chk(wdg_rst_flag === 1'b0, "R1", int'(wdg_rst_flag), 0);

    // R3: write without the activation bit while idle
    tag = "R3";
    wr(2'd0, 10'h07F);
    idle(600);
    chk(npulse == 0, "R3", npulse, 0);

    // R4: expiry from 127, prescaler 1
    tag = "R4";
    wr(2'd1, 10'd94);
    wr(2'd0, 10'h0FF);
    wait_rst(2000, at);
    chk(at - t_wr == 256, "R4", at - t_wr, 256);
    chk(irq === 1'b0, "R8", int'(irq), 0);
    chk(wdg_rst_flag === 1'b1, "R9", int'(wdg_rst_flag), 1);
    @(negedge clk);
    chk(rst_req === 1'b0, "R11", int'(rst_req), 0);
    tag = "R9";
    sreset();
    @(negedge clk);
    chk(wdg_rst_flag === 1'b1, "R9", int'(wdg_rst_flag), 1);
    clear_flag();

    // R2: prescaler codes 2 and 3
    tag = "R2";
    wr(2'd1, (10'd2 << 7) | 10'd94);
    wr(2'd0, 10'h080 | 10'h050);
    wait_rst(2000, at);
    chk(at - t_wr == 272, "R2", at - t_wr, 272);
    sreset(); clear_flag();
    wr(2'd1, (10'd3 << 7) | 10'd94);
    wr(2'd0, 10'h080 | 10'h045);
    wait_rst(2000, at);
    chk(at - t_wr == 192, "R2", at - t_wr, 192);
    sreset(); clear_flag();

    // R7: a write without bit 7 cannot stop or alter the count
    tag = "R7";
    wr(2'd1, 10'd94);
    wr(2'd0, 10'h0FF);
    t0 = t_wr;
    idle(50);
    wr(2'd0, 10'h000);
    wr(2'd0, 10'h01F);
    wait_rst(2000, at);
    chk(at - t0 == 256, "R7", at - t0, 256);
    sreset(); clear_flag();

    // R5: too-early service
    tag = "R5";
    wr(2'd1, 10'd94);
    wr(2'd0, 10'h0FF);
    idle(10);
    wr(2'd0, 10'h0FF);
    wait_rst(4, at);
    chk(at == t_wr, "R5", at - t_wr, 0);
    sreset(); clear_flag();

    // R6: repeated in-window service, then expiry from the last one
    tag = "R6";
    wr(2'd1, 10'd94);
    wr(2'd0, 10'h0FF);
    p0 = npulse;
    for (int k = 0; k < 8; k++) begin
      idle(150);
      wr(2'd0, 10'h0FF);
    end
    chk(npulse == p0, "R6", npulse - p0, 0);
    wait_rst(2000, at);
    chk(at - t_wr == 256, "R6", at - t_wr, 256);
    sreset(); clear_flag();

    // R8: early warning one tick before the request
    tag = "R8";
    wr(2'd1, (10'd1 << 9) | 10'd94);
    wr(2'd0, 10'h080 | 10'h045);
    ir = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (irq === 1'b1) begin ir = cyc; break; end
    end
    chk(ir - t_wr == 20, "R8", ir - t_wr, 20);
    wait_rst(200, at);
    chk(at - ir == FD, "R8", at - ir, FD);
    wr(2'd2, 10'h001);
    @(negedge clk);
    chk(irq === 1'b1, "R8", int'(irq), 1);
    wr(2'd2, 10'h000);
    @(negedge clk);
    chk(irq === 1'b0, "R8", int'(irq), 0);
    chk(wdg_rst_flag === 1'b1, "R9", int'(wdg_rst_flag), 1);
    sreset(); clear_flag();

    // R10: system reset deactivates the watchdog
    tag = "R10";
    wr(2'd1, (10'd1 << 9) | 10'd94);
    wr(2'd0, 10'h0FF);
    idle(20);
    sreset();
    p0 = npulse;
    idle(800);
    chk(npulse == p0, "R10", npulse - p0, 0);
    chk(irq === 1'b0, "R10", int'(irq), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule